// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM with 1024 rows alive by issuing one refresh cycle per fixed interval of system clocks. The default interval of 780 clocks at 50 MHz is 15.6 µs, so all 1024 rows are visited within 16 ms. Each elapsed interval adds one entry to a backlog of owed refreshes. The block asks a host access engine for the memory pins with a request/grant handshake. It begins a cycle only when the grant is present and the host reports that no row is open.

While it owns the pins, the block drives the active-low row strobe, the active-low column strobe and the 10-bit address bus. Two refresh styles are available, chosen per cycle by a mode input. In the first, the column strobe falls before the row strobe, so the device uses its own internal row counter. In the second, the column strobe stays high and the block presents its own row number on the address bus. That row number advances after each cycle of this kind. Every cycle lasts the random cycle time and ends with the row-strobe precharge time, both given as clock counts. The backlog holds up to 8 entries. A sticky flag records a deadline that was lost because the backlog was full.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, ref_req and bus_own are 0, ras_n and cas_n are 1, addr is 0, backlog is 0 and overrun is 0.
- R2: Every INTERVAL_CYC clocks, the backlog grows by one, unless a refresh cycle completes on the same clock.
- R3: ref_req is 1 exactly when no refresh cycle is running and the backlog is non-zero.
- R4: A refresh cycle starts (bus_own rises) on the clock after one where ref_req, ref_gnt and host_idle are all 1. With ref_gnt or host_idle at 0, nothing starts and the pins stay idle.
- R5: Column-first mode (mode_sel = 0): in cycle slot 0, cas_n is 0 and ras_n is 1. In slots 1 to TRC_CYC-TRP_CYC-1, both strobes are 0. addr stays 0.
- R6: Row-address mode (mode_sel = 1): in slots 0 to TRC_CYC-TRP_CYC-1, ras_n is 0, cas_n is 1, and addr holds the internal row number.
- R7: Every refresh cycle keeps bus_own at 1 for exactly TRC_CYC clocks. Its last TRP_CYC clocks have both strobes at 1 (precharge).
- R8: The internal row number starts at 0. It increments after each completed row-address cycle, wraps from 1023 to 0, and is unchanged by column-first cycles.
- R9: The backlog never exceeds 8. An interval that elapses while the backlog is full without a completion sets overrun, which stays set until reset.
- R10: A completed refresh cycle reduces the backlog by one, unless an interval elapses on the same clock.
- R11: mode_sel is sampled only when a cycle starts. Changing it during a cycle does not alter that cycle's strobes or address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = column-first refresh, 1 = row-address refresh |
| host_idle | input | 1 | Host engine has no open row |
| ref_gnt | input | 1 | Host grants the memory pins |
| ref_req | output | 1 | Refresh owed and scheduler idle |
| bus_own | output | 1 | Scheduler is driving the memory pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr | output | 10 | Row address during row-address refresh |
| backlog | output | 4 | Number of owed refreshes |
| overrun | output | 1 | Sticky lost-deadline flag |

## Verification
After rst_n rises, the block needs two clocks of reset synchronization, and the first interval is counted from the third edge. A grant sampled at an edge makes bus_own and the first strobe level visible just after that edge. The backlog drops on the edge that ends the precharge, and the row number moves on that same edge. The bench's reference model advances on the same edges and is compared with every output at the falling clock edge, so each expected value is in place one half clock after the edge that produces it.

// File: rtl/dram_ref_pkg.sv
`timescale 1ns/1ps
package dram_ref_pkg;
  typedef enum logic {
    MODE_COL_FIRST = 1'b0,
    MODE_ROW_ADDR  = 1'b1
  } ref_mode_e;
endpackage

// File: rtl/ref_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, two-stage synchronous release.
module ref_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      srst_n   <= stage1_q;
    end
  end
endmodule

// File: rtl/ref_interval_timer.sv
`timescale 1ns/1ps
// Interval counter plus saturating backlog of owed refreshes.
module ref_interval_timer #(
  parameter int INTERVAL_CYC = 780,
  parameter int BACKLOG_MAX  = 8,
  parameter int BL_W         = $clog2(BACKLOG_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cycle_done,
  output logic [BL_W-1:0] backlog,
  output logic            overrun
);
  localparam int CNT_W = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;

  logic [CNT_W-1:0] icnt_q, icnt_d;
  logic [BL_W-1:0]  pend_q, pend_d;
  logic             ovf_q, ovf_d;
  logic             tick;

  always_comb begin
    tick   = (icnt_q == CNT_W'(INTERVAL_CYC - 1));
    icnt_d = tick ? '0 : icnt_q + 1'b1;
    pend_d = pend_q;
    ovf_d  = ovf_q;
    if (tick && !cycle_done) begin
      if (pend_q == BL_W'(BACKLOG_MAX)) ovf_d  = 1'b1;
      else                              pend_d = pend_q + 1'b1;
    end else if (!tick && cycle_done) begin
      pend_d = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q <= '0;
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      icnt_q <= icnt_d;
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  assign backlog = pend_q;
  assign overrun = ovf_q;
endmodule

// File: rtl/ref_cycle_seq.sv
`timescale 1ns/1ps
// One refresh cycle of TRC_CYC slots, the last TRP_CYC slots in precharge.
module ref_cycle_seq
  import dram_ref_pkg::*;
#(
  parameter int TRC_CYC = 6,
  parameter int TRP_CYC = 2,
  parameter int ROW_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_sel,
  output logic             busy,
  output logic             cycle_done,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] addr
);
  localparam int K_W     = $clog2(TRC_CYC);
  localparam int RAS_END = TRC_CYC - TRP_CYC - 1;

  logic             busy_q, busy_d;
  logic [K_W-1:0]   k_q, k_d;
  ref_mode_e        mode_q, mode_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             strobe_win;

  always_comb begin
    cycle_done = busy_q && (k_q == K_W'(TRC_CYC - 1));
    busy_d = busy_q;
    k_d    = k_q;
    mode_d = mode_q;
    row_d  = row_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      k_d    = '0;
      mode_d = ref_mode_e'(mode_sel);
    end else if (cycle_done) begin
      busy_d = 1'b0;
      if (mode_q == MODE_ROW_ADDR) row_d = row_q + 1'b1;
    end else if (busy_q) begin
      k_d = k_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      k_q    <= '0;
      mode_q <= MODE_COL_FIRST;
      row_q  <= '0;
    end else begin
      busy_q <= busy_d;
      k_q    <= k_d;
      mode_q <= mode_d;
      row_q  <= row_d;
    end
  end

  assign strobe_win = busy_q && (k_q <= K_W'(RAS_END));
  assign busy  = busy_q;
  assign cas_n = !(strobe_win && mode_q == MODE_COL_FIRST);
  assign ras_n = !(strobe_win && (mode_q == MODE_ROW_ADDR || k_q != '0));
  assign addr  = (busy_q && mode_q == MODE_ROW_ADDR) ? row_q : '0;
endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched #(
  parameter int INTERVAL_CYC = 780,
  parameter int TRC_CYC      = 6,
  parameter int TRP_CYC      = 2,
  parameter int ROW_W        = 10,
  parameter int BACKLOG_MAX  = 8,
  parameter int BL_W         = $clog2(BACKLOG_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             host_idle,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             bus_own,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] addr,
  output logic [BL_W-1:0]  backlog,
  output logic             overrun
);
  logic srst_n;
  logic busy;
  logic done;
  logic start;

  ref_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  ref_interval_timer #(
    .INTERVAL_CYC(INTERVAL_CYC), .BACKLOG_MAX(BACKLOG_MAX), .BL_W(BL_W)
  ) u_timer (
    .clk(clk), .rst_n(srst_n), .cycle_done(done),
    .backlog(backlog), .overrun(overrun)
  );

  assign ref_req = !busy && (backlog != '0);
  assign start   = ref_req && ref_gnt && host_idle;
  assign bus_own = busy;

  ref_cycle_seq #(
    .TRC_CYC(TRC_CYC), .TRP_CYC(TRP_CYC), .ROW_W(ROW_W)
  ) u_seq (
    .clk(clk), .rst_n(srst_n), .start(start), .mode_sel(mode_sel),
    .busy(busy), .cycle_done(done),
    .ras_n(ras_n), .cas_n(cas_n), .addr(addr)
  );
endmodule

// File: rtl/dram_refresh_chk.sv
`timescale 1ns/1ps
module dram_refresh_chk #(
  parameter int ROW_W       = 10,
  parameter int BACKLOG_MAX = 8,
  parameter int BL_W        = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_req,
  input logic             ref_gnt,
  input logic             host_idle,
  input logic             bus_own,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] addr,
  input logic [BL_W-1:0]  backlog,
  input logic             overrun
);
  // R3
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !bus_own);
  // R4
  start_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> $past(ref_req && ref_gnt && host_idle));
  // R5
  cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |=> (!ras_n && !cas_n));
  // R6
  row_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && cas_n && $past(!ras_n)) |-> $stable(addr));
  // R7
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> (ras_n && cas_n && addr == '0));
  // R7
  precharge_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> bus_own);
  // R9
  backlog_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backlog <= BL_W'(BACKLOG_MAX));
  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind dram_refresh_sched dram_refresh_chk #(
  .ROW_W(ROW_W), .BACKLOG_MAX(BACKLOG_MAX), .BL_W(BL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt),
  .host_idle(host_idle), .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n),
  .addr(addr), .backlog(backlog), .overrun(overrun)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
  localparam int INTV = 10;
  localparam int TRC  = 6;
  localparam int TRP  = 2;
  localparam int MAXB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0, host_idle = 1'b0, ref_gnt = 1'b0;
  logic ref_req, bus_own, ras_n, cas_n, overrun;
  logic [9:0] addr;
  logic [3:0] backlog;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dram_refresh_sched #(.INTERVAL_CYC(INTV), .TRC_CYC(TRC), .TRP_CYC(TRP))
  u0 (.clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_idle(host_idle),
      .ref_gnt(ref_gnt), .ref_req(ref_req), .bus_own(bus_own), .ras_n(ras_n),
      .cas_n(cas_n), .addr(addr), .backlog(backlog), .overrun(overrun));

  // behavioural reference
  int rs = 0, m_icnt = 0, m_pend = 0, m_k = 0, m_row = 0;
  bit m_ovf = 0, m_busy = 0, m_mode = 0;
  int row_cycles = 0;
  bit wrap_seen = 0;

  always @(posedge clk) begin
    if (!rst_n || rs < 2) begin
      rs = rst_n ? rs + 1 : 0;
      m_icnt = 0; m_pend = 0; m_k = 0; m_row = 0;
      m_ovf = 0; m_busy = 0; m_mode = 0;
    end else begin
      bit tick, fin, st;
      tick = (m_icnt == INTV - 1);
      fin  = m_busy && (m_k == TRC - 1);
      st   = !m_busy && m_pend > 0 && ref_gnt && host_idle;
      m_icnt = tick ? 0 : m_icnt + 1;
      if (tick && !fin) begin
        if (m_pend == MAXB) m_ovf = 1; else m_pend++;
      end else if (!tick && fin) m_pend--;
      if (fin && m_mode) begin
        row_cycles++;
        if (m_row == 1023) wrap_seen = 1;
        m_row = (m_row + 1) % 1024;
      end
      if (st) begin m_busy = 1; m_k = 0; m_mode = mode_sel; end
      else if (fin) m_busy = 0;
      else if (m_busy) m_k++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit low_win, e_ras_low, e_cas_low;
    low_win   = m_busy && (m_k <= TRC - TRP - 1);
    e_ras_low = low_win && (m_mode || m_k >= 1);
    e_cas_low = low_win && !m_mode;
    chk("R3 ref_req", ref_req, (!m_busy && m_pend > 0));
    chk("R4 R7 bus_own", bus_own, m_busy);
    chk("R5 R6 R7 ras_n", ras_n, !e_ras_low);
    chk("R5 R6 R7 cas_n", cas_n, !e_cas_low);
    chk("R6 R8 addr", addr, (m_busy && m_mode) ? m_row : 0);
    chk("R2 R10 backlog", backlog, m_pend);
    chk("R9 overrun", overrun, m_ovf);
  endtask

  task automatic run(input int n, input bit rand_mode, input bit rand_gnt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      if (rand_mode) mode_sel = $urandom_range(0, 1);
      if (rand_gnt) begin
        ref_gnt   = $urandom_range(0, 3) != 0;
        host_idle = $urandom_range(0, 3) != 0;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 ref_req", ref_req, 0);
    chk("R1 bus_own", bus_own, 0);
    chk("R1 ras_n", ras_n, 1);
    chk("R1 cas_n", cas_n, 1);
    chk("R1 addr", addr, 0);
    chk("R1 backlog", backlog, 0);
    chk("R1 overrun", overrun, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R5: column-first refreshes, always granted
    mode_sel = 0; ref_gnt = 1; host_idle = 1;
    run(80, 0, 0);
    // R4: grant present but host row open, nothing may start
    host_idle = 0;
    run(35, 0, 0);
    chk("R4 no start while host busy", bus_own, 0);
    host_idle = 1;
    run(30, 0, 0);
    // R6 R8: row-address refreshes through the 1023 -> 0 wrap
    mode_sel = 1;
    run(1030 * INTV, 0, 0);
    chk("R8 row wrap observed", wrap_seen, 1);
    chk("R8 row-address cycles done", row_cycles >= 1025, 1);
    // R9: starve the block until the backlog is full and a deadline is lost
    ref_gnt = 0;
    run(INTV * (MAXB + 3), 0, 0);
    chk("R9 backlog saturated", backlog, MAXB);
    chk("R9 overrun set", overrun, 1);
    // R10: drain the backlog
    ref_gnt = 1;
    run(INTV * 40, 0, 0);
    chk("R9 overrun sticky", overrun, 1);
    // R11: mode and handshake toggled freely
    run(600, 1, 1);
    do_reset();
    run(50, 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule